// File: doc/BRIEF.md
# Replayable Word Buffer with Half-Full and Cascade Token

A first-in first-out buffer of 1024 nine-bit words (eight data bits plus a parity or framing bit) with a write port and a read port. Each port is driven by its own active-low strobe. Both strobes, the retransmit input and the mode input are sampled on one clock, and the buffer acts on the strobe edges it sees there. A write stores the input word when its strobe returns high. A read presents the next word when its strobe falls and steps past that word when the strobe returns high.

Three active-low status outputs report the fill level: empty, full, and a shared pin. In standalone mode the shared pin is a half-full flag. In depth-cascade mode the same pin carries an expansion token instead. A retransmit request rewinds the read side to location zero so that the words written since reset can be read again. Writes into a full buffer and reads from an empty one are dropped and leave the stored data untouched. The strobes are assumed to be synchronous to the clock already.

Top module: `replay_fifo`

## Requirements
- R1: While reset is low at a clock edge, and after it, the block is empty: `empty_n`=0, `full_n`=1, `xo_hf_n`=1, `dout`=0.
- R2: Words are read back in the order they were written. The stored word is the `din` value at the clock edge where `wr_n` is first seen high after being low.
- R3: A write strobe while 1024 words are held is ignored. `full_n` stays 0 and the stored words are unchanged.
- R4: A read strobe while the buffer is empty is ignored. `dout` keeps its value, `empty_n` stays 0, and no word is lost for later reads.
- R5: `empty_n` is 0 exactly when no word is held. `full_n` is 0 exactly when 1024 words are held.
- R6: With `cascade_en`=0, `xo_hf_n` is 0 exactly when more than 512 words are held.
- R7: With `cascade_en`=0, a clock edge that samples `rt_n`=0 sets the read position to location 0. The word count becomes the number of writes since reset, and the words are then read again from the first. This is valid only while fewer than 1024 writes have occurred since reset.
- R8: With `cascade_en`=1, `rt_n` has no effect on the read position.
- R9: With `cascade_en`=1, `xo_hf_n` never shows the half-full state. It goes low for exactly one cycle after a write lands in the last location (address 1023).
- R10: A write edge and a read-release edge at the same clock edge both take effect. The word count is unchanged, and both words keep their order.
- R11: `dout` changes only at a sampled falling edge of `rd_n` while the buffer is not empty. Writes alone never change it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| din | input | 9 | Word to write |
| cascade_en | input | 1 | 1 = depth-cascade mode, 0 = standalone |
| rt_n | input | 1 | Active-low retransmit request (standalone only) |
| dout | output | 9 | Word being read |
| empty_n | output | 1 | Low when empty |
| full_n | output | 1 | Low when full |
| xo_hf_n | output | 1 | Half-full flag (standalone) or expansion token (cascade), active low |

## Verification
The functions that can fall in the same cycle are a write acceptance and a read advance. The bench makes them coincide by releasing both strobes at the same negative clock edge, after two words are already stored. It then judges the result: the word presented during the read must be the oldest one, no status flag may move, and the following reads must return the remaining old word and then the new one before empty is reached. A second collision is covered by driving a write strobe in the same cycle as a retransmit rewind, which must not lose the written word.

// File: rtl/replay_fifo_pkg.sv
// Shared constants for the replayable buffer.
// Assumes: strobe vectors are indexed by the positions below.
package replay_fifo_pkg;
    localparam int STB_WR    = 0;  // write strobe lane
    localparam int STB_RD    = 1;  // read strobe lane
    localparam int STB_LANES = 2;  // lanes in the strobe sampler
endpackage

// File: rtl/replay_fifo_strobe.sv
// Samples active-low strobes on clk and reports their edges.
// Assumes: strobes are already synchronous to clk.
// rise = the lane was seen low and is now high; fall = the reverse.
module replay_fifo_strobe #(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] stb_n,
    output logic [LANES-1:0] rise,
    output logic [LANES-1:0] fall
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic prev_n;
        // Keep the previous sample of this lane; idle (high) after reset.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_n <= 1'b1;
            else        prev_n <= stb_n[g];
        end
        assign rise[g] =  stb_n[g] & ~prev_n;
        assign fall[g] = ~stb_n[g] &  prev_n;
    end
endmodule

// File: rtl/replay_fifo_store.sv
// Word storage with one write port and a registered read port.
// Assumes: wr_en/rd_en are pre-qualified by the controller.
// The array itself is not reset; only the output register is.
module replay_fifo_store #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             rd_en,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Store an accepted word.
    always_ff @(posedge clk) begin
        if (wr_en) mem[waddr] <= wdata;
    end

    // Present the word at the read position when a read is opened.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= mem[raddr];
    end
endmodule

// File: rtl/replay_fifo_ctrl.sv
// Pointer, occupancy and rewind control.
// Assumes: edge inputs are one-cycle pulses; rewind already gated by mode.
// A read is "armed" at its strobe fall only if a word is held, and
// advances the read pointer at its strobe rise. Rewind wins over an
// advance in the same cycle; a write in that cycle still counts.
module replay_fifo_ctrl #(
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_rise,
    input  logic          rd_fall,
    input  logic          rd_rise,
    input  logic          rewind,
    output logic          wr_en,
    output logic [AW-1:0] waddr,
    output logic          rd_en,
    output logic [AW-1:0] raddr,
    output logic [CW-1:0] occupancy,
    output logic          wrap_pulse
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_ADR = AW'(DEPTH - 1);

    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] cnt;
    logic          armed;
    logic          rd_adv;

    assign wr_en  = wr_rise && (cnt != FULL_CNT);
    assign rd_en  = rd_fall && (cnt != '0) && !rewind;
    assign rd_adv = rd_rise && armed && !rewind;

    assign waddr     = wptr;
    assign raddr     = rptr;
    assign occupancy = cnt;

    // Advance the write pointer on each accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)     wptr <= '0;
        else if (wr_en) wptr <= (wptr == LAST_ADR) ? '0 : wptr + 1'b1;
    end

    // Rewind or advance the read pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)      rptr <= '0;
        else if (rewind) rptr <= '0;
        else if (rd_adv) rptr <= (rptr == LAST_ADR) ? '0 : rptr + 1'b1;
    end

    // Track whether an open read strobe was accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)                  armed <= 1'b0;
        else if (rd_en)              armed <= 1'b1;
        else if (rd_rise || rewind)  armed <= 1'b0;
    end

    // Occupancy: rebuilt from the write pointer on rewind.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (rewind) cnt <= CW'(wptr) + CW'(wr_en);
        else             cnt <= cnt + CW'(wr_en) - CW'(rd_adv);
    end

    // One-cycle token when a write lands in the last location.
    always_ff @(posedge clk) begin
        if (!rst_n) wrap_pulse <= 1'b0;
        else        wrap_pulse <= wr_en && (wptr == LAST_ADR);
    end

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL_CNT);
    a_r3_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == FULL_CNT && !rd_adv && !rewind) |=> (cnt == FULL_CNT));
    a_r4_empty_rptr: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !rewind) |=> $stable(rptr));
    a_r7_rewind_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rewind |=> (rptr == '0));
    a_r10_both_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_adv && !rewind) |=> $stable(cnt));
endmodule

// File: rtl/replay_fifo.sv
// Top of the replayable buffer: strobe sampling, control, storage, flags.
// Assumes: all inputs synchronous to clk; rt_n used only in standalone.
// The shared output shows half-full in standalone mode and the
// wrap token in cascade mode.
module replay_fifo #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_n,
    input  logic             rd_n,
    input  logic [WIDTH-1:0] din,
    input  logic             cascade_en,
    input  logic             rt_n,
    output logic [WIDTH-1:0] dout,
    output logic             empty_n,
    output logic             full_n,
    output logic             xo_hf_n
);
    import replay_fifo_pkg::*;

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [STB_LANES-1:0] stb_n, rise, fall;
    logic                 wr_en, rd_en, wrap_pulse, rewind;
    logic [AW-1:0]        waddr, raddr;
    logic [CW-1:0]        occupancy;

    assign stb_n[STB_WR] = wr_n;
    assign stb_n[STB_RD] = rd_n;
    assign rewind        = !rt_n && !cascade_en;

    replay_fifo_strobe #(.LANES(STB_LANES)) u_strobe (
        .clk(clk), .rst_n(rst_n), .stb_n(stb_n), .rise(rise), .fall(fall)
    );

    replay_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_rise(rise[STB_WR]), .rd_fall(fall[STB_RD]), .rd_rise(rise[STB_RD]),
        .rewind(rewind),
        .wr_en(wr_en), .waddr(waddr), .rd_en(rd_en), .raddr(raddr),
        .occupancy(occupancy), .wrap_pulse(wrap_pulse)
    );

    replay_fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .waddr(waddr), .wdata(din),
        .rd_en(rd_en), .raddr(raddr), .rdata(dout)
    );

    // Status flags from occupancy; shared pin chosen by mode.
    always_comb begin
        empty_n = (occupancy != '0);
        full_n  = (occupancy != FULL_CNT);
        xo_hf_n = cascade_en ? !wrap_pulse : !(occupancy > HALF_CNT);
    end

    a_r11_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !fall[STB_RD] |=> $stable(dout));
    a_r9_token_single: assert property (@(posedge clk) disable iff (!rst_n)
        (cascade_en && !xo_hf_n) |=> (xo_hf_n || !cascade_en));
    a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!empty_n && !full_n));
endmodule

// File: tb/replay_fifo_tb_top.sv
// Directed bench for replay_fifo: one task per scenario.
module replay_fifo_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_n = 1'b1, rd_n = 1'b1, rt_n = 1'b1, cascade_en = 1'b0;
    logic [8:0] din = '0;
    logic [8:0] dout;
    logic       empty_n, full_n, xo_hf_n;
    logic       last_xo;
    int         checks = 0, errors = 0;
    bit         done = 0;

    always #2.5 clk = ~clk;  // 200 MHz

    replay_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .din(din),
        .cascade_en(cascade_en), .rt_n(rt_n), .dout(dout),
        .empty_n(empty_n), .full_n(full_n), .xo_hf_n(xo_hf_n)
    );

    function automatic logic [8:0] pat(input int i);
        return 9'((i * 37 + 5) % 512);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic casc);
        @(negedge clk); rst_n = 1'b0; cascade_en = casc;
        wr_n = 1'b1; rd_n = 1'b1; rt_n = 1'b1;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_write(input logic [8:0] d);
        @(negedge clk); wr_n = 1'b0; din = d;
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk); last_xo = xo_hf_n;
    endtask

    task automatic do_read(output logic [8:0] d);
        @(negedge clk); rd_n = 1'b0;
        @(negedge clk); d = dout; rd_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_rewind();
        @(negedge clk); rt_n = 1'b0;
        @(negedge clk); rt_n = 1'b1;
        @(negedge clk);
    endtask

    // R1 reset state, R2 order, R4 empty read, R11 dout hold
    task automatic t_basic();
        logic [8:0] got;
        do_reset(1'b0);
        check(empty_n == 0, "R1 empty", empty_n, 0);
        check(full_n == 1 && xo_hf_n == 1, "R1 full/hf", {full_n, xo_hf_n}, 3);
        check(dout == 0, "R1 dout", dout, 0);
        for (int i = 0; i < 5; i++) do_write(pat(i));
        check(dout == 0, "R11 dout unchanged by writes", dout, 0);
        check(empty_n == 1, "R5 not empty", empty_n, 1);
        for (int i = 0; i < 5; i++) begin
            do_read(got);
            check(got == pat(i), "R2 order", got, pat(i));
        end
        check(empty_n == 0, "R5 empty after drain", empty_n, 0);
        do_read(got);
        check(dout == pat(4), "R4 empty read keeps dout", dout, pat(4));
        check(empty_n == 0, "R4 still empty", empty_n, 0);
        do_write(9'h0AB);
        check(dout == pat(4), "R11 write while empty keeps dout", dout, pat(4));
        do_read(got);
        check(got == 9'h0AB, "R4 no word lost", got, 9'h0AB);
    endtask

    // R5 full, R6 half-full, R3 overflow ignored
    task automatic t_fill();
        logic [8:0] got;
        do_reset(1'b0);
        for (int i = 0; i < 512; i++) do_write(pat(i));
        check(xo_hf_n == 1, "R6 at 512 not half", xo_hf_n, 1);
        do_write(pat(512));
        check(xo_hf_n == 0, "R6 at 513 half", xo_hf_n, 0);
        for (int i = 513; i < 1023; i++) do_write(pat(i));
        check(full_n == 1, "R5 not full at 1023", full_n, 1);
        do_write(pat(1023));
        check(full_n == 0, "R5 full at 1024", full_n, 0);
        do_write(9'h1AA);
        check(full_n == 0, "R3 full holds", full_n, 0);
        for (int i = 0; i < 1024; i++) begin
            do_read(got);
            check(got == pat(i), "R3 R2 content after overflow", got, pat(i));
            if (i == 0)   check(full_n == 1, "R5 leaves full", full_n, 1);
            if (i == 510) check(xo_hf_n == 0, "R6 at 513 half", xo_hf_n, 0);
            if (i == 511) check(xo_hf_n == 1, "R6 back at 512", xo_hf_n, 1);
        end
        check(empty_n == 0, "R5 empty after 1024 reads", empty_n, 0);
    endtask

    // R7 retransmit, incl. write in the same cycle as the rewind
    task automatic t_rewind();
        logic [8:0] got;
        do_reset(1'b0);
        for (int i = 0; i < 10; i++) do_write(pat(i));
        for (int i = 0; i < 4; i++) do_read(got);
        do_rewind();
        for (int i = 0; i < 10; i++) begin
            do_read(got);
            check(got == pat(i), "R7 replay", got, pat(i));
        end
        check(empty_n == 0, "R7 empty after replay", empty_n, 0);
        // rewind together with a write edge
        @(negedge clk); wr_n = 1'b0; din = 9'h155;
        @(negedge clk); wr_n = 1'b1; rt_n = 1'b0;
        @(negedge clk); rt_n = 1'b1;
        for (int i = 0; i < 10; i++) begin
            do_read(got);
            check(got == pat(i), "R7 replay after write+rewind", got, pat(i));
        end
        do_read(got);
        check(got == 9'h155, "R7 word written with rewind", got, 9'h155);
        check(empty_n == 0, "R7 empty at end", empty_n, 0);
    endtask

    // R10 simultaneous write and read
    task automatic t_both();
        logic [8:0] got;
        do_reset(1'b0);
        do_write(9'h011); do_write(9'h022);
        @(negedge clk); wr_n = 1'b0; rd_n = 1'b0; din = 9'h033;
        @(negedge clk); got = dout; wr_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);
        check(got == 9'h011, "R10 read word during collision", got, 9'h011);
        check(empty_n == 1, "R10 not empty", empty_n, 1);
        do_read(got);
        check(got == 9'h022, "R10 second word", got, 9'h022);
        do_read(got);
        check(got == 9'h033, "R10 collided write kept", got, 9'h033);
        check(empty_n == 0, "R10 count intact", empty_n, 0);
    endtask

    // R8 rewind ignored, R9 token in cascade mode
    task automatic t_cascade();
        logic [8:0] got;
        bit hf_seen = 0;
        do_reset(1'b1);
        do_write(pat(0)); do_write(pat(1)); do_write(pat(2));
        do_read(got);
        do_rewind();
        do_read(got);
        check(got == pat(1), "R8 rewind ignored in cascade", got, pat(1));
        for (int i = 3; i < 1023; i++) begin
            do_write(pat(i));
            if (last_xo == 0) hf_seen = 1;
        end
        check(hf_seen == 0, "R9 no half-full in cascade", hf_seen, 0);
        do_write(pat(1023));
        check(last_xo == 0, "R9 token after last location", last_xo, 0);
        @(negedge clk);
        check(xo_hf_n == 1, "R9 token one cycle", xo_hf_n, 1);
        do_read(got);
        check(got == pat(2), "R8 R2 order kept", got, pat(2));
    endtask

    initial begin
        #(200000 * 5ns);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_basic();
        t_fill();
        t_rewind();
        t_both();
        t_cascade();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule